// File: doc/BRIEF.md
# Receive Frame Address Filter

This block sits behind the receive byte stream of an Ethernet MAC. It decides, for each frame, whether the frame goes on to the application, and it produces two status bits that say whether the destination address check failed and whether the source address check failed. Frame bytes arrive one per cycle, qualified by `byteValid`. The first byte of a frame carries `frameStart` and the last byte carries `frameEnd`. The block stores the first sixteen bytes of the frame: destination, source, type and opcode.

Addresses are compared against a primary station address and `NUM_ENTRIES` extra entries. Each extra entry has a per-byte ignore mask, a select that aims it at the source or the destination field, and an enable. Static configuration inputs choose the filtering policy:

- promiscuous operation,
- inverse destination matching and inverse source matching,
- passing every multicast frame,
- blocking broadcast frames,
- dropping frames whose source check fails,
- receive-all,
- a two-bit policy for control frames.

The verdict appears as a one-cycle pulse in the cycle after the end byte.

Top module: `rx_addr_filter`

## Requirements
- R1: `resultValid` is high for exactly the one clock cycle that follows the cycle in which a byte with `frameEnd` is accepted. Outside that cycle `forward`, `daFail` and `saFail` are 0. All four outputs are 0 after reset.
- R2: Address byte k sits at bits [8k+7:8k] of every 48-bit address port, and byte 0 is the first byte on the wire. A destination equal in all 48 bits to `stationAddr` passes, giving forward=1 and daFail=0. A unicast destination that matches nothing gives forward=0 and daFail=1.
- R3: Bit k of an entry's 6-bit mask (entry e at `entryMask[6e+5:6e]`) set to 1 excludes address byte k from that entry's comparison. An entry whose `entryEnable` bit is 0 never matches.
- R4: An entry whose `entrySrcSel` bit is 1 is compared against the source field (frame bytes 6..11). An entry whose select bit is 0 is compared against the destination field (frame bytes 0..5). When at least one source entry is enabled and none matches, saFail=1. When no source entry is enabled, saFail=0.
- R5: With `cfgSaDrop`=1 a frame with saFail=1 is dropped. With `cfgSaDrop`=0 such a frame is forwarded and still reports saFail=1.
- R6: `cfgDaInvert` inverts the destination match result for both unicast and multicast destinations. `cfgSaInvert` makes a source that matches an enabled source entry fail, and a source that does not match it pass.
- R7: A destination whose byte 0 bit 0 is 1 is multicast. With `cfgPassMcast`=1 every non-broadcast multicast frame passes the destination check. With `cfgPassMcast`=0 a multicast frame follows the normal match.
- R8: An all-ones destination is broadcast. With `cfgBlockBcast`=1 every broadcast frame is dropped, even in promiscuous or receive-all mode. With it 0, broadcast passes the destination check.
- R9: With `cfgPromisc`=1 every frame that is not a blocked broadcast or a control frame is forwarded, and daFail and saFail read 0.
- R10: With `cfgRecvAll`=1 every frame that is not a blocked broadcast or a control frame is forwarded, while daFail and saFail still report the address results.
- R11: A frame whose bytes 12,13 are 0x88,0x08 is a control frame. It is a pause frame if bytes 14,15 are also 0x00,0x01. For control frames, `cfgCtrlPolicy` alone sets `forward`:
  - 2'b00 drops every control frame.
  - 2'b01 forwards every control frame except pause frames, whatever the address result.
  - 2'b10 forwards every control frame.
  - 2'b11 forwards only those control frames whose address checks pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A frame byte is present on byteData |
| byteData | input | 8 | Frame byte |
| frameStart | input | 1 | Marks the first byte of a frame |
| frameEnd | input | 1 | Marks the last byte of a frame |
| cfgPromisc | input | 1 | Promiscuous mode |
| cfgDaInvert | input | 1 | Invert the destination match |
| cfgSaInvert | input | 1 | Invert the source match |
| cfgPassMcast | input | 1 | Pass every multicast destination |
| cfgBlockBcast | input | 1 | Drop every broadcast frame |
| cfgSaDrop | input | 1 | Drop frames that fail the source check |
| cfgRecvAll | input | 1 | Forward all frames, report status |
| cfgCtrlPolicy | input | 2 | Control-frame forwarding policy |
| stationAddr | input | 48 | Primary station address |
| entryAddr | input | 336 | Extra entry addresses, entry e at [48e+47:48e] |
| entryMask | input | 42 | Per-byte ignore masks, entry e at [6e+5:6e] |
| entrySrcSel | input | 7 | 1: entry compares the source field, 0: destination |
| entryEnable | input | 7 | Entry takes part in matching |
| resultValid | output | 1 | Verdict pulse |
| forward | output | 1 | Frame is forwarded |
| daFail | output | 1 | Destination check failed |
| saFail | output | 1 | Source check failed |

## Verification
The assertions check four things on every cycle:
- the verdict outputs stay quiet outside the verdict pulse, and the pulse always follows an accepted end byte;
- a blocked broadcast is never forwarded;
- receive-all never drops an ordinary frame, and a dropping source filter never lets a source failure through;
- promiscuous mode always clears the status bits.

Only the directed scenarios can show the rest:
- that masks exclude exactly the chosen byte;
- that the source/destination select routes an entry to the right field;
- that inverse matching flips the result in both directions;
- that each of the four control-frame policy codes treats pause and non-pause frames as required.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int HDR_BYTES  = 16;
  localparam int IDX_W      = $clog2(HDR_BYTES);
  localparam int CNT_W      = IDX_W + 1;
  localparam int SA_OFS     = 6;
  localparam int TYPE_OFS   = 12;
  localparam int OPC_OFS    = 14;
  localparam logic [15:0] CTRL_TYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPC = 16'h0001;

  typedef struct packed {
    logic             capEn;
    logic             clrHdr;
    logic [IDX_W-1:0] capIdx;
    logic             evalStrobe;
  } strobe_t;

  typedef struct packed {
    logic              promisc;
    logic              daInvert;
    logic              saInvert;
    logic              passMcast;
    logic              blockBcast;
    logic              saDrop;
    logic              recvAll;
    logic [1:0]        ctrlPolicy;
    logic [ADDR_W-1:0] stationAddr;
  } filter_cfg_t;
endpackage

// File: rtl/rx_addr_filter_ctrl.sv
module rx_addr_filter_ctrl
  import rx_addr_filter_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    byteValid,
  input  logic    frameStart,
  input  logic    frameEnd,
  output strobe_t strb
);
  localparam logic [CNT_W-1:0] HDR_MAX = CNT_W'(HDR_BYTES);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] curIdx;
  logic             inFrameQ;
  logic             evalQ;
  logic             startByte;
  logic             acceptByte;

  assign startByte  = byteValid && frameStart;
  assign acceptByte = byteValid && (frameStart || inFrameQ);
  assign curIdx     = startByte ? '0 : cntQ;

  always_comb begin
    strb.capEn      = acceptByte && (curIdx < HDR_MAX);
    strb.clrHdr     = startByte;
    strb.capIdx     = curIdx[IDX_W-1:0];
    strb.evalStrobe = evalQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= '0;
      inFrameQ <= 1'b0;
      evalQ    <= 1'b0;
    end else begin
      evalQ <= acceptByte && frameEnd;
      if (acceptByte) begin
        inFrameQ <= !frameEnd;
        cntQ     <= (curIdx == HDR_MAX) ? curIdx : curIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_addr_filter_dpath.sv
module rx_addr_filter_dpath
  import rx_addr_filter_pkg::*;
#(
  parameter int NUM_ENTRIES = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [7:0]                    byteData,
  input  strobe_t                       strb,
  input  filter_cfg_t                   cfg,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] entryAddr,
  input  logic [NUM_ENTRIES*ADDR_BYTES-1:0] entryMask,
  input  logic [NUM_ENTRIES-1:0]        entrySrcSel,
  input  logic [NUM_ENTRIES-1:0]        entryEnable,
  output logic                          forward,
  output logic                          daFail,
  output logic                          saFail
);
  logic [7:0]        hdrQ [HDR_BYTES];
  logic [ADDR_W-1:0] daVec;
  logic [ADDR_W-1:0] saVec;
  logic [15:0]       typeVal;
  logic [15:0]       opcVal;
  logic [NUM_ENTRIES-1:0] entryHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < HDR_BYTES; k++) hdrQ[k] <= '0;
    end else if (strb.capEn) begin
      if (strb.clrHdr) begin
        for (int k = 1; k < HDR_BYTES; k++) hdrQ[k] <= '0;
        hdrQ[0] <= byteData;
      end else begin
        hdrQ[strb.capIdx] <= byteData;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < ADDR_BYTES; k++) begin
      daVec[8*k +: 8] = hdrQ[k];
      saVec[8*k +: 8] = hdrQ[SA_OFS + k];
    end
    typeVal = {hdrQ[TYPE_OFS], hdrQ[TYPE_OFS+1]};
    opcVal  = {hdrQ[OPC_OFS], hdrQ[OPC_OFS+1]};
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic [ADDR_W-1:0]     cmpVec;
    logic [ADDR_BYTES-1:0] byteOk;
    assign cmpVec = entrySrcSel[e] ? saVec : daVec;
    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
      assign byteOk[b] = entryMask[e*ADDR_BYTES + b] ||
                         (cmpVec[8*b +: 8] == entryAddr[e*ADDR_W + 8*b +: 8]);
    end
    assign entryHit[e] = entryEnable[e] && (&byteOk);
  end

  logic isBcast, isMcast, isCtrl, isPause;
  logic daHit, saHit, saActive;
  logic daFailRaw, saFailRaw, addrPass, fwdRaw;

  assign isBcast  = &daVec;
  assign isMcast  = daVec[0];
  assign isCtrl   = (typeVal == CTRL_TYPE);
  assign isPause  = isCtrl && (opcVal == PAUSE_OPC);
  assign daHit    = (daVec == cfg.stationAddr) || |(entryHit & ~entrySrcSel);
  assign saHit    = |(entryHit & entrySrcSel);
  assign saActive = |(entryEnable & entrySrcSel);

  always_comb begin
    if (isBcast)                        daFailRaw = cfg.blockBcast;
    else if (isMcast && cfg.passMcast)  daFailRaw = 1'b0;
    else                                daFailRaw = !(daHit ^ cfg.daInvert);

    saFailRaw = cfg.saInvert ? saHit : (saActive && !saHit);
    addrPass  = !daFailRaw && !(cfg.saDrop && saFailRaw);

    if (isBcast && cfg.blockBcast) begin
      fwdRaw = 1'b0;
    end else if (isCtrl) begin
      case (cfg.ctrlPolicy)
        2'b00:   fwdRaw = 1'b0;
        2'b01:   fwdRaw = !isPause;
        2'b10:   fwdRaw = 1'b1;
        default: fwdRaw = addrPass;
      endcase
    end else begin
      fwdRaw = cfg.promisc || cfg.recvAll || addrPass;
    end
  end

  assign forward = strb.evalStrobe && fwdRaw;
  assign daFail  = strb.evalStrobe && daFailRaw && !cfg.promisc;
  assign saFail  = strb.evalStrobe && saFailRaw && !cfg.promisc;

  AST_QUIET_OUTSIDE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.evalStrobe |-> !forward && !daFail && !saFail); // R1
  AST_BCAST_BLOCK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.evalStrobe && isBcast && cfg.blockBcast |-> !forward); // R8
  AST_RECV_ALL_FORWARDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.evalStrobe && cfg.recvAll && !isCtrl && !isBcast |-> forward); // R10
  AST_SA_DROP_ENFORCED: assert property (@(posedge clk) disable iff (!rstN)
    strb.evalStrobe && cfg.saDrop && saFail && !isCtrl && !cfg.recvAll |-> !forward); // R5
  AST_PROMISC_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.evalStrobe && cfg.promisc |-> !daFail && !saFail); // R9
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int NUM_ENTRIES = 7
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              byteValid,
  input  logic [7:0]                        byteData,
  input  logic                              frameStart,
  input  logic                              frameEnd,
  input  logic                              cfgPromisc,
  input  logic                              cfgDaInvert,
  input  logic                              cfgSaInvert,
  input  logic                              cfgPassMcast,
  input  logic                              cfgBlockBcast,
  input  logic                              cfgSaDrop,
  input  logic                              cfgRecvAll,
  input  logic [1:0]                        cfgCtrlPolicy,
  input  logic [47:0]                       stationAddr,
  input  logic [NUM_ENTRIES*48-1:0]         entryAddr,
  input  logic [NUM_ENTRIES*6-1:0]          entryMask,
  input  logic [NUM_ENTRIES-1:0]            entrySrcSel,
  input  logic [NUM_ENTRIES-1:0]            entryEnable,
  output logic                              resultValid,
  output logic                              forward,
  output logic                              daFail,
  output logic                              saFail
);
  strobe_t     strb;
  filter_cfg_t cfg;

  always_comb begin
    cfg.promisc     = cfgPromisc;
    cfg.daInvert    = cfgDaInvert;
    cfg.saInvert    = cfgSaInvert;
    cfg.passMcast   = cfgPassMcast;
    cfg.blockBcast  = cfgBlockBcast;
    cfg.saDrop      = cfgSaDrop;
    cfg.recvAll     = cfgRecvAll;
    cfg.ctrlPolicy  = cfgCtrlPolicy;
    cfg.stationAddr = stationAddr;
  end

  rx_addr_filter_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .frameStart (frameStart),
    .frameEnd   (frameEnd),
    .strb       (strb)
  );

  rx_addr_filter_dpath #(.NUM_ENTRIES(NUM_ENTRIES)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .byteData    (byteData),
    .strb        (strb),
    .cfg         (cfg),
    .entryAddr   (entryAddr),
    .entryMask   (entryMask),
    .entrySrcSel (entrySrcSel),
    .entryEnable (entryEnable),
    .forward     (forward),
    .daFail      (daFail),
    .saFail      (saFail)
  );

  assign resultValid = strb.evalStrobe;

  AST_PULSE_FOLLOWS_END: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(byteValid && frameEnd)); // R1
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  localparam int NE        = 7;
  localparam int FRAME_LEN = 20;
  localparam logic [47:0] STA    = 48'hAA9988776602;
  localparam logic [47:0] OTHER  = 48'h000000000004;
  localparam logic [47:0] ENT2   = 48'h665544332200;
  localparam logic [47:0] PROBE  = 48'h775544332200;
  localparam logic [47:0] SA1    = 48'h0A0B0C0D0E10;
  localparam logic [47:0] SA2    = 48'h0A0B0C0D0E20;
  localparam logic [47:0] MCAST  = 48'h000000000001;
  localparam logic [47:0] BCAST  = 48'hFFFFFFFFFFFF;
  localparam logic [15:0] IPV4   = 16'h0800;
  localparam logic [15:0] CTRL   = 16'h8808;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0, frameStart = 1'b0, frameEnd = 1'b0;
  logic [7:0] byteData = '0;
  logic cfgPromisc, cfgDaInvert, cfgSaInvert, cfgPassMcast, cfgBlockBcast, cfgSaDrop, cfgRecvAll;
  logic [1:0] cfgCtrlPolicy;
  logic [47:0] stationAddr;
  logic [NE*48-1:0] entryAddr;
  logic [NE*6-1:0] entryMask;
  logic [NE-1:0] entrySrcSel, entryEnable;
  logic resultValid, forward, daFail, saFail;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_addr_filter #(.NUM_ENTRIES(NE)) u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .frameStart(frameStart), .frameEnd(frameEnd),
    .cfgPromisc(cfgPromisc), .cfgDaInvert(cfgDaInvert), .cfgSaInvert(cfgSaInvert),
    .cfgPassMcast(cfgPassMcast), .cfgBlockBcast(cfgBlockBcast), .cfgSaDrop(cfgSaDrop),
    .cfgRecvAll(cfgRecvAll), .cfgCtrlPolicy(cfgCtrlPolicy), .stationAddr(stationAddr),
    .entryAddr(entryAddr), .entryMask(entryMask), .entrySrcSel(entrySrcSel),
    .entryEnable(entryEnable), .resultValid(resultValid), .forward(forward),
    .daFail(daFail), .saFail(saFail)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic clearCfg();
    cfgPromisc = 0; cfgDaInvert = 0; cfgSaInvert = 0; cfgPassMcast = 0;
    cfgBlockBcast = 0; cfgSaDrop = 0; cfgRecvAll = 0; cfgCtrlPolicy = 2'b00;
    stationAddr = STA; entryAddr = '0; entryMask = '0; entrySrcSel = '0; entryEnable = '0;
  endtask

  function automatic logic [7:0] frameByte(input int i, input logic [47:0] da,
      input logic [47:0] sa, input logic [15:0] typ, input logic [15:0] opc);
    if (i < 6)       return da[8*i +: 8];
    else if (i < 12) return sa[8*(i-6) +: 8];
    else if (i == 12) return typ[15:8];
    else if (i == 13) return typ[7:0];
    else if (i == 14) return opc[15:8];
    else if (i == 15) return opc[7:0];
    return 8'h00;
  endfunction

  task automatic runFrame(input string tag, input logic [47:0] da, input logic [47:0] sa,
      input logic [15:0] typ, input logic [15:0] opc,
      input logic expFwd, input logic expDa, input logic expSa);
    for (int i = 0; i < FRAME_LEN; i++) begin
      @(negedge clk);
      byteValid  = 1'b1;
      frameStart = (i == 0);
      frameEnd   = (i == FRAME_LEN - 1);
      byteData   = frameByte(i, da, sa, typ, opc);
      if (i > 0) check(tag, "early resultValid", resultValid, 1'b0);
    end
    @(negedge clk);
    byteValid = 1'b0; frameStart = 1'b0; frameEnd = 1'b0; byteData = '0;
    check(tag, "resultValid", resultValid, 1'b1);
    check(tag, "forward", forward, expFwd);
    check(tag, "daFail", daFail, expDa);
    check(tag, "saFail", saFail, expSa);
    @(negedge clk);
    check("R1", "pulse end", resultValid, 1'b0);
    check("R1", "forward quiet", forward, 1'b0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "reset resultValid", resultValid, 1'b0);
    check("R1", "reset forward", forward, 1'b0);
    check("R1", "reset daFail", daFail, 1'b0);
    check("R1", "reset saFail", saFail, 1'b0);
  endtask

  task automatic testStationMatch();
    clearCfg();
    runFrame("R2 station hit", STA, SA1, IPV4, 16'h0, 1, 0, 0);
    runFrame("R2 unicast miss", OTHER, SA1, IPV4, 16'h0, 0, 1, 0);
  endtask

  task automatic testEntryMask();
    clearCfg();
    entryAddr[2*48 +: 48] = ENT2;
    entryMask[2*6 +: 6]   = 6'b100000;
    entryEnable[2]        = 1'b1;
    runFrame("R3 masked byte5", PROBE, SA1, IPV4, 16'h0, 1, 0, 0);
    entryMask[2*6 +: 6] = 6'b000000;
    runFrame("R3 unmasked miss", PROBE, SA1, IPV4, 16'h0, 0, 1, 0);
    entryMask[2*6 +: 6] = 6'b100000;
    entryEnable[2]      = 1'b0;
    runFrame("R3 disabled entry", PROBE, SA1, IPV4, 16'h0, 0, 1, 0);
  endtask

  task automatic testSaSelect();
    clearCfg();
    entryAddr[3*48 +: 48] = SA1;
    entrySrcSel[3] = 1'b1;
    entryEnable[3] = 1'b1;
    runFrame("R4 sa hit", STA, SA1, IPV4, 16'h0, 1, 0, 0);
    runFrame("R5 sa miss keep", STA, SA2, IPV4, 16'h0, 1, 0, 1);
    runFrame("R4 sa entry not on da", SA1, SA2, IPV4, 16'h0, 0, 1, 1);
    cfgSaDrop = 1'b1;
    runFrame("R5 sa miss drop", STA, SA2, IPV4, 16'h0, 0, 0, 1);
  endtask

  task automatic testInverse();
    clearCfg();
    entryAddr[3*48 +: 48] = SA1;
    entrySrcSel[3] = 1'b1;
    entryEnable[3] = 1'b1;
    cfgSaInvert = 1'b1;
    runFrame("R6 sa inverse hit", STA, SA1, IPV4, 16'h0, 1, 0, 1);
    runFrame("R6 sa inverse miss", STA, SA2, IPV4, 16'h0, 1, 0, 0);
    clearCfg();
    cfgDaInvert = 1'b1;
    runFrame("R6 da inverse hit", STA, SA1, IPV4, 16'h0, 0, 1, 0);
    runFrame("R6 da inverse miss", OTHER, SA1, IPV4, 16'h0, 1, 0, 0);
    runFrame("R6 da inverse mcast", MCAST, SA1, IPV4, 16'h0, 1, 0, 0);
  endtask

  task automatic testMulticast();
    clearCfg();
    runFrame("R7 mcast no pass", MCAST, SA1, IPV4, 16'h0, 0, 1, 0);
    cfgPassMcast = 1'b1;
    runFrame("R7 mcast pass", MCAST, SA1, IPV4, 16'h0, 1, 0, 0);
    runFrame("R7 unicast unaffected", OTHER, SA1, IPV4, 16'h0, 0, 1, 0);
  endtask

  task automatic testBroadcast();
    clearCfg();
    runFrame("R8 bcast open", BCAST, SA1, IPV4, 16'h0, 1, 0, 0);
    cfgBlockBcast = 1'b1;
    runFrame("R8 bcast blocked", BCAST, SA1, IPV4, 16'h0, 0, 1, 0);
    cfgPromisc = 1'b1; cfgRecvAll = 1'b1;
    runFrame("R8 bcast blocked override", BCAST, SA1, IPV4, 16'h0, 0, 0, 0);
  endtask

  task automatic testPromisc();
    clearCfg();
    entryAddr[3*48 +: 48] = SA1;
    entrySrcSel[3] = 1'b1;
    entryEnable[3] = 1'b1;
    cfgSaDrop  = 1'b1;
    cfgPromisc = 1'b1;
    runFrame("R9 promisc", OTHER, SA2, IPV4, 16'h0, 1, 0, 0);
  endtask

  task automatic testReceiveAll();
    clearCfg();
    entryAddr[3*48 +: 48] = SA1;
    entrySrcSel[3] = 1'b1;
    entryEnable[3] = 1'b1;
    cfgSaDrop  = 1'b1;
    cfgRecvAll = 1'b1;
    runFrame("R10 recv all", OTHER, SA2, IPV4, 16'h0, 1, 1, 1);
  endtask

  task automatic testControl();
    clearCfg();
    cfgCtrlPolicy = 2'b00;
    runFrame("R11 policy00", STA, SA1, CTRL, 16'h0001, 0, 0, 0);
    cfgCtrlPolicy = 2'b01;
    runFrame("R11 policy01 pause", OTHER, SA1, CTRL, 16'h0001, 0, 1, 0);
    runFrame("R11 policy01 other", OTHER, SA1, CTRL, 16'h0002, 1, 1, 0);
    cfgCtrlPolicy = 2'b10;
    runFrame("R11 policy10", OTHER, SA1, CTRL, 16'h0001, 1, 1, 0);
    cfgCtrlPolicy = 2'b11;
    runFrame("R11 policy11 fail", OTHER, SA1, CTRL, 16'h0001, 0, 1, 0);
    runFrame("R11 policy11 pass", STA, SA1, CTRL, 16'h0001, 1, 0, 0);
    cfgRecvAll = 1'b1;
    runFrame("R11 policy11 over recvall", OTHER, SA1, CTRL, 16'h0001, 0, 1, 0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    clearCfg();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testStationMatch();
    testEntryMask();
    testSaSelect();
    testInverse();
    testMulticast();
    testBroadcast();
    testPromisc();
    testReceiveAll();
    testControl();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end
endmodule